// File: doc/BRIEF.md
# HyperBus Host Transaction Sequencer

This block is the host side of an 8-bit double-data-rate memory bus that has a chip select, a bus clock and a strobe that both ends can drive. A core asks for one transaction at a time over a level request. The request carries the direction, the target space (memory array or configuration registers), the burst style, a word address and a word count. The sequencer first sends a 48-bit command-address word. While that word goes out, it reads the latency indication that the memory puts on the strobe. It then waits out the initial latency and moves the data words. When the last word is done, it raises chip select and gives a one-cycle acknowledge.

The block runs on an internal clock at twice the bus clock rate. Each internal cycle is one half of a bus clock period and carries exactly one byte on the data pins. Write words are taken from the core one at a time through a pop strobe. A word is held in the block until both of its bytes have been sent. On reads, bytes are captured on the transitions of the strobe driven by the memory, so the block keeps working when the memory holds the strobe between words. Each completed read word is handed back with a one-cycle valid.

Top module: `hb_seq_master`

## Requirements
- R1: Chip select falls with the bus clock low. While chip select is low, the bus clock toggles on every internal cycle. While chip select is high, the bus clock stays low.
- R2: Command-address is six cycles, most significant byte first, with the data output enable high. Bit 47 is 1 for a read, bit 46 is 1 for register space, and bit 45 is 1 for a linear burst (the inverse of the wrap request, forced to 1 for register writes). Bits 44:16 hold address bits above bit 2, bits 15:3 are zero, and bits 2:0 hold the low three address bits.
- R3: The strobe input is sampled only in the sixth command-address cycle. The latency phase then lasts 2×cfg internal cycles when the strobe was low and 4×cfg when it was high, with a cfg of 0 taken as 1. The strobe at any other time has no effect on latency.
- R4: The strobe output enable is low during command-address. On memory writes it is high for the whole latency phase with a low strobe, which forms the preamble.
- R5: A write word goes out in two cycles, bits 15:8 first and then bits 7:0. The strobe carries the inverse of the byte enable: be[1] for the first byte, be[0] for the second. A high strobe masks that byte.
- R6: A register write has no latency phase. Its data follows the sixth command-address cycle at once, the strobe output enable stays low, and exactly one word is sent whatever length was asked for.
- R7: The write-data pop is high in each cycle whose closing edge takes wr_data and wr_be: the last cycle before the data phase, and the second-byte cycle of every word except the last.
- R8: During read data, the byte present when the strobe rises becomes bits 15:8 and the byte present when it falls becomes bits 7:0. rd_valid pulses one cycle after the falling strobe. Any number of held-strobe cycles may come before a word.
- R9: From the end of command-address to the end of a read, both the data and the strobe output enables stay low.
- R10: Exactly the latched word count is moved, with 0 taken as 1. After the last word, chip select goes high for one cycle with ack high, and ack is never high for two cycles in a row.
- R11: A request is accepted only while idle. Its fields and cfg_lat are latched when it is accepted, so later changes have no effect. Chip select stays high for at least the ack cycle plus one idle cycle.
- R12: In reset and after it, chip select is high, the bus clock is low, and both output enables, ack, wd_pop and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transaction request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = register space, 0 = memory array |
| req_wrap | input | 1 | 1 = wrapped burst, 0 = linear |
| req_addr | input | ADDR_W | Word address |
| req_len | input | LEN_W | Number of words (0 taken as 1) |
| cfg_lat | input | CFG_W | Initial latency in bus clocks |
| wr_data | input | 16 | Current write word |
| wr_be | input | 2 | Byte enables of the current write word |
| wd_pop | output | 1 | wr_data and wr_be are taken at the coming edge |
| rd_valid | output | 1 | rd_data holds a new read word |
| rd_data | output | 16 | Read word, first byte in bits 15:8 |
| ack | output | 1 | Transaction finished |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck | output | 1 | Bus clock |
| hb_dq_out | output | 8 | Data pins, host driven value |
| hb_dq_oe | output | 1 | Data pins output enable |
| hb_dq_in | input | 8 | Data pins, memory driven value |
| hb_rwds_out | output | 1 | Strobe, host driven value |
| hb_rwds_oe | output | 1 | Strobe output enable |
| hb_rwds_in | input | 1 | Strobe, memory driven value |

## Verification
The bench flips the strobe during the latency phase of writes. A sequencer that sampled the latency flag anywhere other than the last command-address cycle would then shorten or stretch the latency, and every later data byte would land in the wrong cycle. Reads are given held-strobe gaps before words and back-to-back words with no gap. A design that counted cycles instead of following strobe edges would capture gap bytes, and one that swapped byte lanes would return words with their halves reversed. A register write is asked for with a length of five, a high latency flag and the wrap bit set. A design that ran a latency phase, drove the strobe, sent more than one word or cleared the linear bit would fail on the first data cycle or in the command-address bytes. Request fields are also changed after acceptance, to catch a design that reads the live inputs instead of latching them.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    localparam int CA_W       = 48;
    localparam int CA_BYTES   = 6;
    localparam int CA_RD_BIT  = 47;
    localparam int CA_REG_BIT = 46;
    localparam int CA_LIN_BIT = 45;
    localparam int CA_UP_LSB  = 16;
    localparam int CA_UP_W    = 29;
    localparam int CA_LO_W    = 3;
    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA,
        ST_LAT,
        ST_DATA,
        ST_END
    } seq_st_e;

    typedef struct packed {
        logic wr;
        logic rs;
        logic wrap;
    } op_t;

    // register writes must be linear; otherwise the bit is the inverse of wrap
    function automatic logic lin_bit(input op_t op);
        return (op.wr && op.rs) ? 1'b1 : !op.wrap;
    endfunction

endpackage

// File: rtl/hb_ca_gen.sv
module hb_ca_gen
    import hb_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  op_t               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        idx,
    output logic [7:0]        ca_byte
);

    logic [CA_W-1:0]   ca;
    logic [BYTE_W-1:0] ca_slices [CA_BYTES];

    always_comb begin
        ca                         = '0;
        ca[CA_RD_BIT]              = !op.wr;
        ca[CA_REG_BIT]             = op.rs;
        ca[CA_LIN_BIT]             = lin_bit(op);
        ca[CA_UP_LSB +: CA_UP_W]   = CA_UP_W'(addr >> CA_LO_W);
        ca[CA_LO_W-1:0]            = addr[CA_LO_W-1:0];
    end

    // most significant byte leaves first
    for (genvar g = 0; g < CA_BYTES; g++) begin : g_slice
        assign ca_slices[g] = ca[CA_W-1-BYTE_W*g -: BYTE_W];
    end

    always_comb begin
        ca_byte = '0;
        for (int i = 0; i < CA_BYTES; i++) begin
            if (idx == 3'(i)) ca_byte = ca_slices[i];
        end
    end

endmodule

// File: rtl/hb_lat_ctr.sv
module hb_lat_ctr #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg,
    input  logic             dbl,
    input  logic             run,
    output logic             last
);

    localparam int CNT_W = CFG_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] total;

    // two internal cycles per bus clock, doubled on a high flag
    always_comb begin
        total = CNT_W'(cfg) << 1;
        if (cfg == '0) total = CNT_W'(2);
        if (dbl) total = total << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= total;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/hb_rd_capture.sv
module hb_rd_capture
    import hb_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rwds_in,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              word_done,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    logic              rwds_d;
    logic [BYTE_W-1:0] hi_byte;
    logic              rise;

    assign rise      = en && rwds_in && !rwds_d;
    assign word_done = en && !rwds_in && rwds_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rwds_d   <= 1'b0;
            hi_byte  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rwds_d   <= rwds_in;
            rd_valid <= word_done;
            if (rise) hi_byte <= dq_in;
            if (word_done) rd_data <= {hi_byte, dq_in};
        end
    end

endmodule

// File: rtl/hb_seq_master.sv
module hb_seq_master
    import hb_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 6,
    parameter int CFG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_reg,
    input  logic              req_wrap,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CFG_W-1:0]  cfg_lat,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        wr_be,
    output logic              wd_pop,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              ack,
    output logic              hb_cs_n,
    output logic              hb_ck,
    output logic [7:0]        hb_dq_out,
    output logic              hb_dq_oe,
    input  logic [7:0]        hb_dq_in,
    output logic              hb_rwds_out,
    output logic              hb_rwds_oe,
    input  logic              hb_rwds_in
);

    localparam logic [2:0]       CA_LAST = 3'(CA_BYTES - 1);
    localparam logic [LEN_W-1:0] ONE_W   = LEN_W'(1);

    seq_st_e            st;
    op_t                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [CFG_W-1:0]   cfg_q;
    logic [LEN_W-1:0]   wleft;
    logic [2:0]         ca_idx;
    logic               half;
    logic               ph;
    logic [WORD_W-1:0]  wbuf;
    logic [1:0]         wbe;

    logic in_ca, in_lat, in_data, active;
    logic reg_wr, mem_wr;
    logic ca_last, lat_last, last_word;
    logic rd_word_done, word_end;
    logic [7:0] ca_byte;

    assign in_ca     = (st == ST_CA);
    assign in_lat    = (st == ST_LAT);
    assign in_data   = (st == ST_DATA);
    assign active    = in_ca || in_lat || in_data;
    assign reg_wr    = op_q.wr && op_q.rs;
    assign mem_wr    = op_q.wr && !op_q.rs;
    assign ca_last   = in_ca && (ca_idx == CA_LAST);
    assign last_word = (wleft == ONE_W);
    assign word_end  = in_data && (op_q.wr ? half : rd_word_done);

    hb_ca_gen #(.ADDR_W(ADDR_W)) u_ca (
        .op      (op_q),
        .addr    (addr_q),
        .idx     (ca_idx),
        .ca_byte (ca_byte)
    );

    hb_lat_ctr #(.CFG_W(CFG_W)) u_lat (
        .clk  (clk),
        .rst  (rst),
        .load (ca_last),
        .cfg  (cfg_q),
        .dbl  (hb_rwds_in),
        .run  (in_lat),
        .last (lat_last)
    );

    hb_rd_capture u_rd (
        .clk       (clk),
        .rst       (rst),
        .en        (in_data && !op_q.wr),
        .rwds_in   (hb_rwds_in),
        .dq_in     (hb_dq_in),
        .word_done (rd_word_done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // a word is taken just before the data phase and after each second byte
    assign wd_pop = op_q.wr && ((ca_last && reg_wr) ||
                                (in_lat && lat_last) ||
                                (in_data && half && !last_word));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op_q   <= '0;
            addr_q <= '0;
            cfg_q  <= '0;
            wleft  <= '0;
            ca_idx <= '0;
            half   <= 1'b0;
            ph     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req) begin
                        op_q   <= '{wr: req_write, rs: req_reg, wrap: req_wrap};
                        addr_q <= req_addr;
                        cfg_q  <= cfg_lat;
                        if ((req_write && req_reg) || req_len == '0) wleft <= ONE_W;
                        else wleft <= req_len;
                        ca_idx <= '0;
                        ph     <= 1'b0;
                        st     <= ST_CA;
                    end
                end
                ST_CA: begin
                    ph     <= !ph;
                    ca_idx <= ca_idx + 3'd1;
                    if (ca_last) begin
                        half <= 1'b0;
                        st   <= reg_wr ? ST_DATA : ST_LAT;
                    end
                end
                ST_LAT: begin
                    ph <= !ph;
                    if (lat_last) begin
                        half <= 1'b0;
                        st   <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    ph <= !ph;
                    if (op_q.wr) half <= !half;
                    if (word_end) begin
                        if (last_word) st <= ST_END;
                        else wleft <= wleft - ONE_W;
                    end
                end
                ST_END: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf <= '0;
            wbe  <= '0;
        end else if (wd_pop) begin
            wbuf <= wr_data;
            wbe  <= wr_be;
        end
    end

    assign hb_cs_n     = !active;
    assign hb_ck       = active && ph;
    assign hb_dq_oe    = in_ca || (in_data && op_q.wr);
    assign hb_dq_out   = in_ca ? ca_byte : (half ? wbuf[7:0] : wbuf[15:8]);
    assign hb_rwds_oe  = mem_wr && (in_lat || in_data);
    assign hb_rwds_out = in_data && !(half ? wbe[0] : wbe[1]);
    assign ack         = (st == ST_END);

endmodule

// File: rtl/hb_seq_master_chk.sv
module hb_seq_master_chk (
    input logic clk,
    input logic rst,
    input logic hb_cs_n,
    input logic hb_ck,
    input logic hb_dq_oe,
    input logic hb_rwds_oe,
    input logic ack,
    input logic wd_pop,
    input logic rd_valid
);

    // R1
    cs_fall_ck_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hb_cs_n) |-> !hb_ck);

    // R1
    ck_parked_chk: assert property (@(posedge clk) disable iff (rst)
        hb_cs_n |-> !hb_ck);

    // R1
    ck_toggles_chk: assert property (@(posedge clk) disable iff (rst)
        (!hb_cs_n && !$past(hb_cs_n)) |-> (hb_ck != $past(hb_ck)));

    // R4
    ca_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hb_cs_n) |-> (!hb_rwds_oe && hb_dq_oe));

    // R9
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!hb_dq_oe && !hb_rwds_oe));

    // R10
    ack_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> hb_cs_n);

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R7
    pop_in_txn_chk: assert property (@(posedge clk) disable iff (rst)
        wd_pop |-> (!hb_cs_n && !ack));

endmodule

bind hb_seq_master hb_seq_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hb_cs_n    (hb_cs_n),
    .hb_ck      (hb_ck),
    .hb_dq_oe   (hb_dq_oe),
    .hb_rwds_oe (hb_rwds_oe),
    .ack        (ack),
    .wd_pop     (wd_pop),
    .rd_valid   (rd_valid)
);

// File: tb/tb_hb_seq_master.sv
module tb_hb_seq_master;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;
    localparam int CFG_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_write = 1'b0, req_reg = 1'b0, req_wrap = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [CFG_W-1:0]  cfg_lat = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic wd_pop, rd_valid, ack, hb_cs_n, hb_ck, hb_dq_oe, hb_rwds_out, hb_rwds_oe;
    logic [15:0] rd_data;
    logic [7:0]  hb_dq_out;
    logic [7:0]  hb_dq_in = '0;
    logic        hb_rwds_in = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_seq_master #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_reg(req_reg),
        .req_wrap(req_wrap), .req_addr(req_addr), .req_len(req_len), .cfg_lat(cfg_lat),
        .wr_data(wr_data), .wr_be(wr_be), .wd_pop(wd_pop), .rd_valid(rd_valid),
        .rd_data(rd_data), .ack(ack), .hb_cs_n(hb_cs_n), .hb_ck(hb_ck),
        .hb_dq_out(hb_dq_out), .hb_dq_oe(hb_dq_oe), .hb_dq_in(hb_dq_in),
        .hb_rwds_out(hb_rwds_out), .hb_rwds_oe(hb_rwds_oe), .hb_rwds_in(hb_rwds_in)
    );

    typedef struct {
        bit cs_n; bit ck; bit dq_oe; bit [7:0] dq_out;
        bit rwds_oe; bit rwds_out; bit pop; bit rdv; bit [15:0] rdd; bit ack;
        bit rin; bit [7:0] din; string tag;
    } rec_t;

    rec_t exp_q[$];
    bit [15:0] wq[$];
    bit [1:0]  bq[$];
    bit [15:0] rq[$];
    int        gq[$];
    int n_checks = 0;
    int n_fail = 0;

    function automatic rec_t idle_rec(string tag);
        rec_t r;
        r.cs_n = 1; r.ck = 0; r.dq_oe = 0; r.dq_out = 0; r.rwds_oe = 0; r.rwds_out = 0;
        r.pop = 0; r.rdv = 0; r.rdd = 0; r.ack = 0; r.rin = 0; r.din = 0; r.tag = tag;
        return r;
    endfunction

    task automatic check(rec_t e);
        bit bad = 0;
        string m = "";
        n_checks++;
        if (hb_cs_n !== e.cs_n) begin bad = 1; m = $sformatf("cs_n act %0b exp %0b", hb_cs_n, e.cs_n); end
        else if (hb_ck !== e.ck) begin bad = 1; m = $sformatf("ck act %0b exp %0b", hb_ck, e.ck); end
        else if (hb_dq_oe !== e.dq_oe) begin bad = 1; m = $sformatf("dq_oe act %0b exp %0b", hb_dq_oe, e.dq_oe); end
        else if (e.dq_oe && hb_dq_out !== e.dq_out) begin bad = 1; m = $sformatf("dq_out act %02h exp %02h", hb_dq_out, e.dq_out); end
        else if (hb_rwds_oe !== e.rwds_oe) begin bad = 1; m = $sformatf("rwds_oe act %0b exp %0b", hb_rwds_oe, e.rwds_oe); end
        else if (e.rwds_oe && hb_rwds_out !== e.rwds_out) begin bad = 1; m = $sformatf("rwds_out act %0b exp %0b", hb_rwds_out, e.rwds_out); end
        else if (wd_pop !== e.pop) begin bad = 1; m = $sformatf("wd_pop act %0b exp %0b", wd_pop, e.pop); end
        else if (rd_valid !== e.rdv) begin bad = 1; m = $sformatf("rd_valid act %0b exp %0b", rd_valid, e.rdv); end
        else if (e.rdv && rd_data !== e.rdd) begin bad = 1; m = $sformatf("rd_data act %04h exp %04h", rd_data, e.rdd); end
        else if (ack !== e.ack) begin bad = 1; m = $sformatf("ack act %0b exp %0b", ack, e.ack); end
        if (bad) begin
            n_fail++;
            $display("FAIL %s at %0t: %s", e.tag, $time, m);
        end
    endtask

    // behavioural model: expected per-cycle outputs and memory-side stimulus
    task automatic build(bit wr, bit rs, bit wrap, bit [31:0] addr, int len, int cfg, bit flag);
        int nw = (wr && rs) ? 1 : ((len == 0) ? 1 : len);
        int lat = (wr && rs) ? 0 : 2 * ((cfg == 0) ? 1 : cfg) * (flag ? 2 : 1);
        bit lin = (wr && rs) ? 1'b1 : !wrap;
        bit [47:0] ca = {!wr, rs, lin, 29'(addr >> 3), 13'd0, addr[2:0]};
        int cyc = 0;
        bit pend = 0;
        bit [15:0] pword = 0;
        rec_t r;
        exp_q.delete();
        for (int k = 0; k < 6; k++) begin
            r = idle_rec("R1 R2 R4");
            r.cs_n = 0; r.ck = cyc[0]; r.dq_oe = 1; r.dq_out = ca[47-8*k -: 8];
            r.rin = flag; r.pop = (k == 5) && wr && (lat == 0);
            exp_q.push_back(r); cyc++;
        end
        for (int j = 0; j < lat; j++) begin
            r = idle_rec("R3 R4 R7 R9");
            r.cs_n = 0; r.ck = cyc[0]; r.rwds_oe = wr && !rs; r.rwds_out = 0;
            r.rin = wr ? !flag : 1'b0; r.pop = wr && (j == lat - 1);
            exp_q.push_back(r); cyc++;
        end
        if (wr) begin
            for (int w = 0; w < nw; w++) begin
                r = idle_rec(rs ? "R6" : "R5");
                r.cs_n = 0; r.ck = cyc[0]; r.dq_oe = 1; r.dq_out = wq[w][15:8];
                r.rwds_oe = !rs; r.rwds_out = !bq[w][1];
                exp_q.push_back(r); cyc++;
                r = idle_rec(rs ? "R6 R7" : "R5 R7");
                r.cs_n = 0; r.ck = cyc[0]; r.dq_oe = 1; r.dq_out = wq[w][7:0];
                r.rwds_oe = !rs; r.rwds_out = !bq[w][0]; r.pop = (w < nw - 1);
                exp_q.push_back(r); cyc++;
            end
        end else begin
            for (int w = 0; w < nw; w++) begin
                for (int g = 0; g < gq[w] + 2; g++) begin
                    r = idle_rec("R8 R9");
                    r.cs_n = 0; r.ck = cyc[0];
                    if (g < gq[w]) begin r.rin = 0; r.din = 8'h5A ^ 8'(g); end
                    else if (g == gq[w]) begin r.rin = 1; r.din = rq[w][15:8]; end
                    else begin r.rin = 0; r.din = rq[w][7:0]; end
                    if (pend) begin r.rdv = 1; r.rdd = pword; pend = 0; end
                    exp_q.push_back(r); cyc++;
                end
                pend = 1; pword = rq[w];
            end
        end
        r = idle_rec("R10");
        r.ack = 1;
        if (pend) begin r.rdv = 1; r.rdd = pword; end
        exp_q.push_back(r);
    endtask

    task automatic run_txn(bit wr, bit rs, bit wrap, bit [31:0] addr, int len, int cfg, bit flag);
        int pops = 0;
        bit first = 1;
        build(wr, rs, wrap, addr, len, cfg, flag);
        @(negedge clk);
        check(idle_rec("R11 idle"));
        req = 1; req_write = wr; req_reg = rs; req_wrap = wrap;
        req_addr = addr; req_len = LEN_W'(len); cfg_lat = CFG_W'(cfg);
        while (exp_q.size() > 0) begin
            rec_t r = exp_q.pop_front();
            @(negedge clk);
            hb_rwds_in = r.rin;
            hb_dq_in = r.din;
            wr_data = (pops < wq.size()) ? wq[pops] : 16'hDEAD;
            wr_be = (pops < bq.size()) ? bq[pops] : 2'b00;
            if (first) begin
                // R11: changes after acceptance must not matter
                req_addr = ~addr; req_len = ~LEN_W'(len); cfg_lat = ~CFG_W'(cfg); req_wrap = !wrap;
                first = 0;
            end
            if (r.ack) req = 0;
            check(r);
            if (r.pop) pops++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog: act hung exp finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (2) @(negedge clk);
        check(idle_rec("R12 in reset"));
        rst = 0;
        @(negedge clk);
        check(idle_rec("R12 after reset"));

        // memory write, single latency, mixed byte enables (R3 R4 R5 R7)
        wq = '{16'h1234, 16'hABCD, 16'h0F0F}; bq = '{2'b11, 2'b10, 2'b01};
        run_txn(1, 0, 0, 32'h0012_3459, 3, 3, 0);

        // memory write, doubled latency, wrapped, fully masked word
        wq = '{16'hCAFE, 16'h55AA}; bq = '{2'b00, 2'b11};
        run_txn(1, 0, 1, 32'hFFFF_FFF8, 2, 2, 1);

        // register write: R6 one word, no latency, linear bit forced
        wq = '{16'h8F1F, 16'h1111}; bq = '{2'b00, 2'b00};
        run_txn(1, 1, 1, 32'h0000_0801, 5, 4, 1);

        // linear memory read with gaps (R8 R9)
        rq = '{16'hA1B2, 16'hC3D4, 16'hE5F6}; gq = '{0, 2, 1};
        run_txn(0, 0, 0, 32'h0ABC_DEF7, 3, 2, 0);

        // wrapped read with doubled latency
        rq = '{16'h0102, 16'hFEFD}; gq = '{1, 0};
        run_txn(0, 0, 1, 32'h8000_0003, 2, 1, 1);

        // register read
        rq = '{16'h8F2C}; gq = '{0};
        run_txn(0, 1, 0, 32'h0000_0000, 1, 3, 0);

        // memory write, latency code 0 taken as 1, doubled
        wq = '{16'h7E81}; bq = '{2'b01};
        run_txn(1, 0, 0, 32'h0000_0010, 1, 0, 1);

        // longer read, back-to-back words, len 0 taken as 1 in a second read
        rq = '{16'h1111, 16'h2222, 16'h3333, 16'h4444}; gq = '{3, 0, 0, 2};
        run_txn(0, 0, 0, 32'h1234_5678, 4, 4, 1);
        rq = '{16'h9ABC}; gq = '{0};
        run_txn(0, 0, 0, 32'h0000_0007, 0, 2, 0);

        @(negedge clk);
        check(idle_rec("R10 R11 final idle"));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule